// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Stop-Bit Check

This block receives asynchronous serial frames on a single input line and presents each received byte to a microcontroller-style register interface. The line is oversampled on a 16x tick from an external rate generator, so the receiver keeps its own bit timing and never depends on any transmit-side clocking. Frames carry either eight data bits (mode 1) or nine data bits (modes 2 and 3). Data arrives least significant bit first, between one low start bit and one stop bit.

Two byte-wide registers control the block. The control register holds the mode, the receive enable, the ninth received bit and the receive-done flag. The power register holds a select bit that turns on stop-bit checking. While that select bit is set, bit 7 of the control register reads and writes a sticky framing-error flag instead of the upper mode bit. The two are held in separate flops. Turning the check on also moves the point at which the receive-done flag rises: from the end of the last data bit to the middle of the stop bit.

Top module: `serial_rx_ferr`

## Requirements
- R1: After reset, both registers read 0x00, the received-byte output is 0x00 and the receive-done flag is 0.
- R2: Control register layout, bit 7 down to 0: upper mode bit or error flag, lower mode bit, spare, receive enable, transmit ninth bit, received ninth bit, transmit done, receive done. Bits 6..0 read back as written. Power register bit 6 is the check select and bit 5 always reads 0; the other power bits read back as written.
- R3: With power bit 6 = 1, control bit 7 reads and writes the framing-error flag. With it 0, bit 7 reads and writes the upper mode bit. Writing through one view never changes the other.
- R4: Mode 1 (mode bits 01) receives 8 data bits LSB first into the byte output and sets receive done. The sampled stop-bit value is stored in control bit 2.
- R5: Modes 2 and 3 (mode bits 10, 11) receive 9 data bits. The ninth bit is stored in control bit 2, which is also the `rx_bit9` output.
- R6: With the check selected, a frame whose stop bit samples as 0 sets the framing-error flag.
- R7: The framing-error flag stays set through later frames with a valid stop bit. Only a control write of 0 to bit 7 under the check view, or a reset, clears it.
- R8: With the check selected, receive done rises at the middle of the stop bit. Otherwise it rises at the end of the last data bit, before the stop bit is sampled.
- R9: No frame is received while receive enable is 0 or the mode bits are 00. An enable dropped mid-frame aborts the frame.
- R10: A falling edge whose start bit does not vote low at its middle returns the receiver to idle without a flag. The next frame is then received normally.
- R11: Each bit value is the majority of oversamples 7, 8 and 9 (counted from 0) of its 16, so one corrupted oversample does not change it.
- R12: With the check not selected, a zero stop bit still delivers the byte and leaves the framing-error flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control register, 1 power register |
| wr_data | input | 8 | Write data |
| ctl_rd | output | 8 | Control register readback (bit 7 aliased) |
| pwr_rd | output | 8 | Power register readback |
| rx_byte | output | 8 | Last received data byte |
| rx_bit9 | output | 1 | Received ninth bit or stop bit (control bit 2) |
| rx_flag | output | 1 | Receive done (control bit 0) |

## Verification
A register write is visible on the readback one clock after the strobe, and the bench samples it at the following falling edge. A frame's results are due about three clocks plus up to one tick after the receiver's own bit boundary: two synchronizer stages plus the edge detector. The bench therefore reads the byte, ninth bit and flags only after two idle bit times, well clear of that window. The flag-timing check instead samples the done flag a quarter of the way into the stop bit. That point lies after the early rise and before the mid-stop rise by more than the worst-case lag, so it separates the two cases.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned REG_W  = 8;

    localparam logic SEL_CTL = 1'b0;
    localparam logic SEL_PWR = 1'b1;

    localparam int unsigned PWR_CHK_BIT = 6;
    localparam logic [REG_W-1:0] PWR_MASK = 8'hDF;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic mode_hi;
        logic mode_lo;
        logic spare;
        logic rx_en;
        logic tx_b9;
        logic rx_b9;
        logic tx_done;
        logic rx_done;
    } ctl_t;

    typedef struct packed {
        logic              done;
        logic              stop_seen;
        logic              stop_bit;
        logic              ninth;
        logic [BYTE_W-1:0] data;
    } rx_evt_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] sr_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sr_q   <= {sr_q[STAGES-2:0], din};
            prev_q <= sr_q[STAGES-1];
        end
    end

    assign dout = sr_q[STAGES-1];
    assign fall = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    line,
    input  logic    fall,
    input  logic    enable,
    input  logic    nine,
    input  logic    chk,
    output rx_evt_t evt,
    output logic    busy
);
    localparam int unsigned CW    = $clog2(OVS);
    localparam int unsigned IW    = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] S_A  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] S_B  = CW'(OVS / 2);
    localparam logic [CW-1:0] S_C  = CW'(OVS / 2 + 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_e         state_q;
    logic [CW-1:0]     sub_q;
    logic [IW-1:0]     idx_q;
    logic              sa_q, sb_q;
    logic [BYTE_W-1:0] sh_q;
    logic              ninth_q;
    rx_evt_t           evt_q;
    logic              vote;
    logic [IW-1:0]     last_idx;

    assign vote     = maj3(sa_q, sb_q, line);
    assign last_idx = nine ? IW'(BYTE_W) : IW'(BYTE_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
            sa_q    <= 1'b1;
            sb_q    <= 1'b1;
            sh_q    <= '0;
            ninth_q <= 1'b0;
            evt_q   <= '0;
        end else begin
            evt_q.done      <= 1'b0;
            evt_q.stop_seen <= 1'b0;
            if (!enable) begin
                state_q <= RX_IDLE;
            end else if (state_q == RX_IDLE) begin
                if (fall) begin
                    state_q <= RX_START;
                    sub_q   <= '0;
                end
            end else if (tick) begin
                sub_q <= (sub_q == LAST) ? '0 : sub_q + 1'b1;
                if (sub_q == S_A) sa_q <= line;
                if (sub_q == S_B) sb_q <= line;
                case (state_q)
                    RX_START: begin
                        if (sub_q == S_C && vote) begin
                            state_q <= RX_IDLE;
                        end else if (sub_q == LAST) begin
                            state_q <= RX_DATA;
                            idx_q   <= '0;
                        end
                    end
                    RX_DATA: begin
                        if (sub_q == S_C) begin
                            if (idx_q == IW'(BYTE_W)) ninth_q <= vote;
                            else sh_q <= {vote, sh_q[BYTE_W-1:1]};
                        end
                        if (sub_q == LAST) begin
                            if (idx_q == last_idx) begin
                                state_q <= RX_STOP;
                                if (!chk) begin
                                    evt_q.done  <= 1'b1;
                                    evt_q.data  <= sh_q;
                                    evt_q.ninth <= ninth_q;
                                end
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    RX_STOP: begin
                        if (sub_q == S_C) begin
                            state_q         <= RX_IDLE;
                            evt_q.stop_seen <= 1'b1;
                            evt_q.stop_bit  <= vote;
                            if (chk) begin
                                evt_q.done  <= 1'b1;
                                evt_q.data  <= sh_q;
                                evt_q.ninth <= ninth_q;
                            end
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign evt  = evt_q;
    assign busy = (state_q != RX_IDLE);
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  rx_evt_t           evt,
    output logic [REG_W-1:0]  ctl_rd,
    output logic [REG_W-1:0]  pwr_rd,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_flag,
    output logic              rx_on,
    output logic              nine,
    output logic              chk,
    output logic              fe,
    output logic              mode_hi
);
    ctl_t              ctl_q;
    logic              fe_q;
    logic [REG_W-1:0]  pwr_q;
    logic [BYTE_W-1:0] byte_q;
    logic              wr_ctl, wr_pwr;

    assign chk    = pwr_q[PWR_CHK_BIT];
    assign nine   = ctl_q.mode_hi;
    assign rx_on  = ctl_q.rx_en & (ctl_q.mode_hi | ctl_q.mode_lo);
    assign wr_ctl = wr_en & (wr_sel == SEL_CTL);
    assign wr_pwr = wr_en & (wr_sel == SEL_PWR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            fe_q   <= 1'b0;
            pwr_q  <= '0;
            byte_q <= '0;
        end else begin
            if (wr_ctl) begin
                ctl_q.mode_lo <= wr_data[6];
                ctl_q.spare   <= wr_data[5];
                ctl_q.rx_en   <= wr_data[4];
                ctl_q.tx_b9   <= wr_data[3];
                ctl_q.rx_b9   <= wr_data[2];
                ctl_q.tx_done <= wr_data[1];
                ctl_q.rx_done <= wr_data[0];
                if (chk) fe_q <= wr_data[7];
                else     ctl_q.mode_hi <= wr_data[7];
            end
            if (wr_pwr) pwr_q <= wr_data & PWR_MASK;
            if (evt.done) begin
                byte_q        <= evt.data;
                ctl_q.rx_done <= 1'b1;
                if (nine) ctl_q.rx_b9 <= evt.ninth;
            end
            if (evt.stop_seen) begin
                if (!nine) ctl_q.rx_b9 <= evt.stop_bit;
                if (chk && !evt.stop_bit) fe_q <= 1'b1;
            end
        end
    end

    assign ctl_rd  = {chk ? fe_q : ctl_q.mode_hi, ctl_q[REG_W-2:0]};
    assign pwr_rd  = pwr_q;
    assign rx_byte = byte_q;
    assign rx_bit9 = ctl_q.rx_b9;
    assign rx_flag = ctl_q.rx_done;
    assign fe      = fe_q;
    assign mode_hi = ctl_q.mode_hi;
endmodule

// File: rtl/serial_rx_ferr.sv
module serial_rx_ferr
    import serial_rx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              os_tick,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  ctl_rd,
    output logic [REG_W-1:0]  pwr_rd,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_flag
);
    logic    line_s, line_fall;
    logic    rx_on, nine, chk_en, fe_q, mode_hi_q;
    logic    frm_busy, frm_done, frm_stop, frm_stop_bit;
    rx_evt_t evt;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s),
        .fall (line_fall)
    );

    serial_rx_frame #(.OVS(OVS)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick   (os_tick),
        .line   (line_s),
        .fall   (line_fall),
        .enable (rx_on),
        .nine   (nine),
        .chk    (chk_en),
        .evt    (evt),
        .busy   (frm_busy)
    );

    serial_rx_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .evt     (evt),
        .ctl_rd  (ctl_rd),
        .pwr_rd  (pwr_rd),
        .rx_byte (rx_byte),
        .rx_bit9 (rx_bit9),
        .rx_flag (rx_flag),
        .rx_on   (rx_on),
        .nine    (nine),
        .chk     (chk_en),
        .fe      (fe_q),
        .mode_hi (mode_hi_q)
    );

    assign frm_done     = evt.done;
    assign frm_stop     = evt.stop_seen;
    assign frm_stop_bit = evt.stop_bit;
endmodule

// File: rtl/serial_rx_ferr_chk.sv
module serial_rx_ferr_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic wr_sel,
    input logic chk_en,
    input logic fe_q,
    input logic mode_hi_q,
    input logic rx_flag,
    input logic rx_on,
    input logic frm_busy,
    input logic frm_done,
    input logic frm_stop,
    input logic frm_stop_bit
);
    logic ctl_wr;
    assign ctl_wr = wr_en & ~wr_sel;

    AST_MODE_HELD_UNDER_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && chk_en) |=> $stable(mode_hi_q)); // R3

    AST_FLAG_HELD_UNDER_MODE: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !chk_en) |=> $stable(fe_q)); // R3

    AST_FE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fe_q && !ctl_wr) |=> fe_q); // R7

    AST_FE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(fe_q) && !$past(ctl_wr)) |-> $past(frm_stop && !frm_stop_bit && chk_en)); // R6

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_flag) && !$past(ctl_wr)) |-> $past(frm_done)); // R8

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !rx_on |=> !frm_busy); // R9
endmodule

bind serial_rx_ferr serial_rx_ferr_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .chk_en       (chk_en),
    .fe_q         (fe_q),
    .mode_hi_q    (mode_hi_q),
    .rx_flag      (rx_flag),
    .rx_on        (rx_on),
    .frm_busy     (frm_busy),
    .frm_done     (frm_done),
    .frm_stop     (frm_stop),
    .frm_stop_bit (frm_stop_bit)
);

// File: tb/tb_serial_rx_ferr.sv
module tb_serial_rx_ferr;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT_CLKS  = 4;
    localparam int OVS        = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctl_rd, pwr_rd, rx_byte;
    logic       rx_bit9, rx_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int tdiv = 0;

    serial_rx_ferr dut (
        .clk     (clk),
        .rst     (rst),
        .rxd     (rxd),
        .os_tick (os_tick),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctl_rd  (ctl_rd),
        .pwr_rd  (pwr_rd),
        .rx_byte (rx_byte),
        .rx_bit9 (rx_bit9),
        .rx_flag (rx_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tdiv    = (tdiv + 1) % SLOT_CLKS;
            os_tick = (tdiv == 0);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic has9, input logic b9,
                        input logic stopv, input int glitch, output logic ri_early);
        logic [10:0] fr;
        int n;
        fr = '1;
        fr[0] = 1'b0;
        fr[8:1] = b;
        if (has9) begin fr[9] = b9; fr[10] = stopv; n = 11; end
        else begin fr[9] = stopv; n = 10; end
        ri_early = 1'b0;
        for (int i = 0; i < n; i++) begin
            for (int s = 0; s < OVS; s++) begin
                if (i == n - 1 && s == 4) ri_early = rx_flag;
                rxd = (i == glitch && s == OVS/2) ? ~fr[i] : fr[i];
                repeat (SLOT_CLKS) @(negedge clk);
            end
        end
        rxd = 1'b1;
        repeat (2 * OVS * SLOT_CLKS) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 ctl", ctl_rd, 8'h00);
        check("R1 pwr", pwr_rd, 8'h00);
        check("R1 byte", rx_byte, 8'h00);
        check("R1 flag", rx_flag, 1'b0);
    endtask

    task automatic t_regs();
        wr(1'b1, 8'hFF);
        check("R2 pwr mask", pwr_rd, 8'hDF);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h2B);
        check("R2 ctl readback", ctl_rd, 8'h2B);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_alias();
        wr(1'b0, 8'hD0);
        check("R3 mode view", ctl_rd, 8'hD0);
        wr(1'b1, 8'h40);
        check("R3 flag view clear", ctl_rd, 8'h50);
        wr(1'b0, 8'hD0);
        check("R3 flag set by write", ctl_rd, 8'hD0);
        wr(1'b1, 8'h00);
        check("R3 mode kept", ctl_rd, 8'hD0);
        wr(1'b0, 8'h50);
        check("R3 mode cleared", ctl_rd, 8'h50);
        wr(1'b1, 8'h40);
        check("R3 flag kept", ctl_rd, 8'hD0);
        wr(1'b0, 8'h50);
        check("R3 flag cleared", ctl_rd, 8'h50);
        wr(1'b1, 8'h00);
        check("R3 mode still 0", ctl_rd[7], 1'b0);
    endtask

    task automatic t_mode1();
        logic e;
        wr(1'b0, 8'h50);
        send(8'hA5, 1'b0, 1'b0, 1'b1, -1, e);
        check("R4 byte", rx_byte, 8'hA5);
        check("R4 flag", rx_flag, 1'b1);
        check("R4 stop in bit2", rx_bit9, 1'b1);
        check("R8 early flag unchecked", e, 1'b1);
        wr(1'b0, 8'h50);
        send(8'h3C, 1'b0, 1'b0, 1'b0, -1, e);
        check("R12 byte", rx_byte, 8'h3C);
        check("R12 flag", rx_flag, 1'b1);
        check("R4 zero stop in bit2", rx_bit9, 1'b0);
        wr(1'b1, 8'h40);
        check("R12 no error", ctl_rd[7], 1'b0);
    endtask

    task automatic t_check();
        logic e;
        wr(1'b0, 8'h50);
        send(8'h5A, 1'b0, 1'b0, 1'b1, -1, e);
        check("R8 no early flag", e, 1'b0);
        check("R8 flag at stop", rx_flag, 1'b1);
        check("R6 good stop", ctl_rd[7], 1'b0);
        check("R6 byte", rx_byte, 8'h5A);
        wr(1'b0, 8'h50);
        send(8'h81, 1'b0, 1'b0, 1'b0, -1, e);
        check("R6 error set", ctl_rd[7], 1'b1);
        check("R6 byte bad stop", rx_byte, 8'h81);
        wr(1'b0, 8'hD0);
        send(8'h42, 1'b0, 1'b0, 1'b1, -1, e);
        check("R7 sticky", ctl_rd[7], 1'b1);
        check("R7 byte", rx_byte, 8'h42);
        wr(1'b0, 8'h50);
        check("R7 cleared", ctl_rd[7], 1'b0);
        wr(1'b1, 8'h00);
        check("R3 mode after error", ctl_rd[7], 1'b0);
    endtask

    task automatic t_nine();
        logic e;
        wr(1'b0, 8'hD0);
        send(8'h99, 1'b1, 1'b1, 1'b1, -1, e);
        check("R5 byte", rx_byte, 8'h99);
        check("R5 ninth 1", rx_bit9, 1'b1);
        wr(1'b0, 8'hD0);
        send(8'h12, 1'b1, 1'b0, 1'b1, -1, e);
        check("R5 byte b", rx_byte, 8'h12);
        check("R5 ninth 0", rx_bit9, 1'b0);
        wr(1'b0, 8'h90);
        send(8'h77, 1'b1, 1'b1, 1'b1, -1, e);
        check("R5 mode2 byte", rx_byte, 8'h77);
        check("R5 mode2 ninth", rx_bit9, 1'b1);
        check("R5 mode2 flag", rx_flag, 1'b1);
    endtask

    task automatic t_disabled();
        logic e;
        wr(1'b0, 8'h40);
        send(8'hEE, 1'b0, 1'b0, 1'b1, -1, e);
        check("R9 enable off flag", rx_flag, 1'b0);
        check("R9 enable off byte", rx_byte, 8'h77);
        wr(1'b0, 8'h10);
        send(8'hEE, 1'b0, 1'b0, 1'b1, -1, e);
        check("R9 mode0 flag", rx_flag, 1'b0);
        check("R9 mode0 byte", rx_byte, 8'h77);
    endtask

    task automatic t_false_start();
        logic e;
        wr(1'b0, 8'h50);
        rxd = 1'b0;
        repeat (4 * SLOT_CLKS) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * OVS * SLOT_CLKS) @(negedge clk);
        check("R10 no flag", rx_flag, 1'b0);
        check("R10 byte kept", rx_byte, 8'h77);
        send(8'h33, 1'b0, 1'b0, 1'b1, -1, e);
        check("R10 next frame", rx_byte, 8'h33);
        check("R10 next flag", rx_flag, 1'b1);
    endtask

    task automatic t_glitch();
        logic e;
        wr(1'b0, 8'h50);
        send(8'h0F, 1'b0, 1'b0, 1'b1, 3, e);
        check("R11 glitch on one", rx_byte, 8'h0F);
        wr(1'b0, 8'h50);
        send(8'h0F, 1'b0, 1'b0, 1'b1, 6, e);
        check("R11 glitch on zero", rx_byte, 8'h0F);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_alias();
        t_mode1();
        t_check();
        t_nine();
        t_disabled();
        t_false_start();
        t_glitch();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule